// File: doc/BRIEF.md
# Debug Halt and Core Register Access Controller

This block sits between a debugger-side register bus and a small processor core. It keeps a debug-enable flag, a sticky halt request and a halted status. The halted status drives the core's stop input. Breakpoint and watchpoint match pulses coming from the core can raise the halt request, but only while debugging is enabled.

While the core is stopped, the debugger reaches any core register indirectly. It first places a value in the data register, or leaves it alone for a read. It then writes the selector register with a register number and a direction. The block runs one request/acknowledge transfer on the core's register-file port. For a read, it captures the returned value into the data register. A ready flag in the control word reports that the transfer has finished. The bank holds general registers R0 to R12 plus special registers (stack pointer, link, program counter, status and others), 20 entries by default.

The bus is a single-cycle write strobe with a word address and a combinational read port. Word 0 is the control/status word, word 1 the selector and word 2 the data register. Word 3 reads as zero.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset the control word, selector and data register all read zero. `core_halt` and `rf_req` are low.
- R2: In the control word, bit 0 is debug enable and bit 1 is the halt request. On reads, bit 16 is the halted status and bit 17 is register-ready. A write with bits 0 and 1 both set stores the halt request at that edge, and `core_halt` and bit 16 go high one clock later.
- R3: A halt bit written together with bit 0 clear is not stored, and the core keeps running.
- R4: Writing the control word with bit 1 clear (or bit 0 clear) releases the core. `core_halt` stays high for one more clock and drops on the following one.
- R5: With debug enabled, a one-cycle `bkpt_match` or `wpt_match` pulse sets the halt request bit, and `core_halt` rises one clock after the pulse is taken. The request stays set until the debugger clears it.
- R6: With debug disabled, breakpoint and watchpoint pulses are ignored: the halt request stays low and the core keeps running.
- R7: In the selector word, bits 4:0 give the register number (4 selects R4) and bit 16 gives the direction (1 = write core register, 0 = read). Any selector write clears register-ready at that edge.
- R8: A read transfer on a halted core loads the selected core register's value into the data register and then sets register-ready.
- R9: A write transfer on a halted core copies the data register into the selected core register and then sets register-ready.
- R10: A selector write while the core is running issues no `rf_req`, leaves register-ready low, and changes neither the data register nor any core register.
- R11: A selector write naming a register number at or above the bank size (20) is treated the same way: no request, ready stays low, no register changes.
- R12: `rf_req` with stable `rf_idx`, `rf_we` and `rf_wdata` is held until `rf_ack`. Register-ready rises on the clock after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe from the debugger bus |
| bus_addr | input | 2 | Word address: 0 control, 1 selector, 2 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| bkpt_match | input | 1 | Breakpoint comparator hit |
| wpt_match | input | 1 | Watchpoint comparator hit |
| core_halt | output | 1 | Stop request to the core (halted status) |
| rf_req | output | 1 | Register-file access request |
| rf_we | output | 1 | 1 = write `rf_wdata` into the register, 0 = read |
| rf_idx | output | 5 | Core register number |
| rf_wdata | output | 32 | Value for a register write |
| rf_rdata | input | 32 | Value returned for a register read, valid with `rf_ack` |
| rf_ack | input | 1 | Register-file access complete |

## Verification
The bench sweeps all 32 selector codes in both directions on a halted core. It then reads every core register back and compares it with the pattern computed for its index. This catches a swapped direction bit, a truncated index or a data register that is not captured. Codes 20 to 31 must leave the ready bit low and every register untouched; a design that wraps or clips the index would corrupt a low register.

The bench counts request pulses and checks that the count does not change when transfers are requested on a running core; a design that ignores the halted state would issue a request. It also checks the one-cycle lag of the halted status on both entry and release. A design with no lag, or with an extra cycle of lag, fails at the exact sample point. Finally, it pulses the event inputs with debug disabled; a design that does not gate them would stop the core.

// File: rtl/dbg_pkg.sv
// Shared definitions for the debug halt/register-access block.
// Assumes a 32-bit debugger bus with word addresses 0..3.
package dbg_pkg;
    typedef enum logic [1:0] {
        WORD_CTRL = 2'd0,
        WORD_SEL  = 2'd1,
        WORD_DATA = 2'd2,
        WORD_NONE = 2'd3
    } dbg_word_e;

    localparam int CTRL_EN_BIT     = 0;
    localparam int CTRL_HALT_BIT   = 1;
    localparam int CTRL_HALTED_BIT = 16;
    localparam int CTRL_READY_BIT  = 17;
    localparam int SEL_DIR_BIT     = 16;
endpackage

// File: rtl/dbg_run_ctrl.sv
// Run/halt control: holds debug enable and the sticky halt request, and
// derives the halted status one clock after the request.
// Assumes ctrl_wr is a single-cycle strobe; a control write wins over an
// event in the same cycle.
module dbg_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_en_bit,
    input  logic wr_halt_bit,
    input  logic bkpt_match,
    input  logic wpt_match,
    output logic en_q,
    output logic halt_req_q,
    output logic halted_q
);
    logic event_hit;

    // Either comparator hit counts as a debug event.
    always_comb event_hit = bkpt_match | wpt_match;

    // Update enable and halt request from bus writes and debug events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            halt_req_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q       <= wr_en_bit;
            halt_req_q <= wr_en_bit & wr_halt_bit;
        end else if (en_q && event_hit) begin
            halt_req_q <= 1'b1;
        end
    end

    // Halted status follows the enabled halt request by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) halted_q <= 1'b0;
        else        halted_q <= en_q & halt_req_q;
    end

    // R6
    events_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ctrl_wr && !halt_req_q) |=> !halt_req_q);
    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_req_q |=> !halted_q);
    // R2
    halt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req_q && en_q) |=> halted_q);
    // R3
    halt_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_en_bit) |=> !halt_req_q);
endmodule

// File: rtl/dbg_xfer.sv
// Core register transfer engine: owns the selector and data registers,
// runs one req/ack access on the register-file port per accepted selector
// write, and keeps the register-ready flag.
// Assumes rf_ack is only asserted while rf_req is high.
module dbg_xfer #(
    parameter int DATA_W        = 32,
    parameter int IDX_W         = 5,
    parameter int NUM_CORE_REGS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted,
    input  logic              sel_wr,
    input  logic [IDX_W-1:0]  sel_idx_in,
    input  logic              sel_dir_in,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    output logic [IDX_W-1:0]  sel_idx_q,
    output logic              sel_dir_q,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q,
    output logic              rf_req,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic              rf_ack
);
    localparam logic [IDX_W:0] REG_LIMIT = (IDX_W+1)'(NUM_CORE_REGS);

    logic busy_q;
    logic idx_ok;
    logic start;
    logic done;

    // Accept a transfer only for an in-range register on a halted core.
    always_comb begin
        idx_ok = ({1'b0, sel_idx_in} < REG_LIMIT);
        start  = sel_wr && !busy_q && halted && idx_ok;
        done   = busy_q && rf_ack;
    end

    // Selector register: frozen while a transfer is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx_q <= '0;
            sel_dir_q <= 1'b0;
        end else if (sel_wr && !busy_q) begin
            sel_idx_q <= sel_idx_in;
            sel_dir_q <= sel_dir_in;
        end
    end

    // Transfer state and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            if (start)       busy_q <= 1'b1;
            else if (done)   busy_q <= 1'b0;
            if (sel_wr)      ready_q <= 1'b0;
            else if (done)   ready_q <= 1'b1;
        end
    end

    // Data register: loaded by a read return, or by the bus when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  data_q <= '0;
        else if (done && !sel_dir_q) data_q <= rf_rdata;
        else if (data_wr && !busy_q) data_q <= data_in;
    end

    // Drive the register-file port from the frozen selector and data.
    always_comb begin
        rf_req   = busy_q;
        rf_we    = sel_dir_q;
        rf_idx   = sel_idx_q;
        rf_wdata = data_q;
    end

    // R7
    sel_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> !ready_q);
    // R10
    req_only_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_req) |-> $past(halted));
    // R11
    req_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> ({1'b0, rf_idx} < REG_LIMIT));
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_ack) |=> (rf_req && $stable(rf_idx) && $stable(rf_we)
                                 && $stable(rf_wdata)));
    // R12
    ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(rf_ack));
endmodule

// File: rtl/dbg_halt_ctrl.sv
// Top of the debug halt and core register access block: decodes the
// debugger register bus, instantiates run control and the transfer engine,
// and assembles the read word.
// Assumes a single-cycle write strobe and combinational reads.
module dbg_halt_ctrl #(
    parameter int DATA_W        = 32,
    parameter int IDX_W         = 5,
    parameter int NUM_CORE_REGS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bkpt_match,
    input  logic              wpt_match,
    output logic              core_halt,
    output logic              rf_req,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic              rf_ack
);
    import dbg_pkg::*;

    dbg_word_e        word;
    logic             ctrl_wr, sel_wr, data_wr;
    logic             en_q, halt_req_q, halted_q;
    logic [IDX_W-1:0] sel_idx_q;
    logic             sel_dir_q;
    logic [DATA_W-1:0] data_q;
    logic             ready_q;

    // Decode the bus write strobe per register word.
    always_comb begin
        word    = dbg_word_e'(bus_addr);
        ctrl_wr = bus_wr && (word == WORD_CTRL);
        sel_wr  = bus_wr && (word == WORD_SEL);
        data_wr = bus_wr && (word == WORD_DATA);
    end

    dbg_run_ctrl u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .wr_en_bit  (bus_wdata[CTRL_EN_BIT]),
        .wr_halt_bit(bus_wdata[CTRL_HALT_BIT]),
        .bkpt_match (bkpt_match),
        .wpt_match  (wpt_match),
        .en_q       (en_q),
        .halt_req_q (halt_req_q),
        .halted_q   (halted_q)
    );

    dbg_xfer #(
        .DATA_W       (DATA_W),
        .IDX_W        (IDX_W),
        .NUM_CORE_REGS(NUM_CORE_REGS)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .halted    (halted_q),
        .sel_wr    (sel_wr),
        .sel_idx_in(bus_wdata[IDX_W-1:0]),
        .sel_dir_in(bus_wdata[SEL_DIR_BIT]),
        .data_wr   (data_wr),
        .data_in   (bus_wdata),
        .sel_idx_q (sel_idx_q),
        .sel_dir_q (sel_dir_q),
        .data_q    (data_q),
        .ready_q   (ready_q),
        .rf_req    (rf_req),
        .rf_we     (rf_we),
        .rf_idx    (rf_idx),
        .rf_wdata  (rf_wdata),
        .rf_rdata  (rf_rdata),
        .rf_ack    (rf_ack)
    );

    // Stop output follows the halted status.
    always_comb core_halt = halted_q;

    // Assemble the read word for the addressed register.
    always_comb begin
        bus_rdata = '0;
        unique case (word)
            WORD_CTRL: begin
                bus_rdata[CTRL_EN_BIT]     = en_q;
                bus_rdata[CTRL_HALT_BIT]   = halt_req_q;
                bus_rdata[CTRL_HALTED_BIT] = halted_q;
                bus_rdata[CTRL_READY_BIT]  = ready_q;
            end
            WORD_SEL: begin
                bus_rdata[IDX_W-1:0]   = sel_idx_q;
                bus_rdata[SEL_DIR_BIT] = sel_dir_q;
            end
            WORD_DATA: bus_rdata = data_q;
            WORD_NONE: bus_rdata = '0;
        endcase
    end

    // R5
    event_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !ctrl_wr && (bkpt_match || wpt_match)) |=> ##1 core_halt);
endmodule

// File: tb/tb_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_halt_ctrl;
    localparam int DW = 32;
    localparam int IW = 5;
    localparam int NREG = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic bkpt_match = 1'b0, wpt_match = 1'b0;
    logic core_halt, rf_req, rf_we;
    logic [IW-1:0] rf_idx;
    logic [DW-1:0] rf_wdata;
    logic [DW-1:0] rf_rdata;
    logic rf_ack;

    int checks = 0;
    int fails = 0;
    int req_count = 0;
    logic req_d;
    logic [DW-1:0] cregs [NREG];

    always #4 clk = ~clk;

    dbg_halt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bkpt_match(bkpt_match), .wpt_match(wpt_match),
        .core_halt(core_halt), .rf_req(rf_req), .rf_we(rf_we),
        .rf_idx(rf_idx), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .rf_ack(rf_ack)
    );

    function automatic logic [DW-1:0] init_val(int i);
        return 32'hC0DE0000 + i;
    endfunction

    function automatic logic [DW-1:0] pat(int i);
        return 32'hA5000000 + i * 32'h00010101;
    endfunction

    // Core register-file model: acknowledges one clock after a request.
    always @(posedge clk) begin
        if (!rst_n) begin
            rf_ack   <= 1'b0;
            rf_rdata <= '0;
            for (int i = 0; i < NREG; i++) cregs[i] <= init_val(i);
        end else begin
            rf_ack <= rf_req && !rf_ack;
            if (rf_req && !rf_ack) begin
                rf_rdata <= cregs[rf_idx];
                if (rf_we) cregs[rf_idx] <= rf_wdata;
            end
        end
    end

    // Count request pulses seen at the port.
    always @(posedge clk) begin
        req_d <= rf_req;
        if (rst_n && rf_req && !req_d) req_count <= req_count + 1;
    end

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic bus_write(logic [1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_ready(output logic got);
        logic [DW-1:0] w;
        got = 1'b0;
        for (int k = 0; k < 8 && !got; k++) begin
            @(negedge clk);
            bus_read(2'd0, w);
            got = w[17];
        end
    endtask

    task automatic pulse(logic b);
        @(negedge clk);
        if (b) bkpt_match = 1'b1; else wpt_match = 1'b1;
        @(negedge clk);
        bkpt_match = 1'b0; wpt_match = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [DW-1:0] w;
        logic got;
        int rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        bus_read(2'd0, w); check("R1 ctrl", w, 0);
        bus_read(2'd1, w); check("R1 sel", w, 0);
        bus_read(2'd2, w); check("R1 data", w, 0);
        check("R1 core_halt", {31'd0, core_halt}, 0);
        check("R1 rf_req", {31'd0, rf_req}, 0);

        // R6 events ignored with debug disabled
        pulse(1'b1); pulse(1'b0);
        @(negedge clk);
        check("R6 core_halt", {31'd0, core_halt}, 0);
        bus_read(2'd0, w); check("R6 ctrl", w, 0);

        // R3 halt bit without enable
        bus_write(2'd0, 32'h2);
        @(negedge clk);
        bus_read(2'd0, w); check("R3 ctrl", w, 0);
        check("R3 core_halt", {31'd0, core_halt}, 0);

        // R10 transfer while running
        rc = req_count;
        bus_write(2'd2, 32'h12345678);
        bus_write(2'd1, 32'h0001_0005);
        wait_ready(got);
        check("R10 ready", {31'd0, got}, 0);
        check("R10 req count", rc, req_count);
        check("R10 creg5", cregs[5], init_val(5));
        bus_write(2'd1, 32'h0000_0003);
        wait_ready(got);
        check("R10 read ready", {31'd0, got}, 0);
        bus_read(2'd2, w); check("R10 data", w, 32'h12345678);

        // R2 halt with lag of one clock
        bus_write(2'd0, 32'h3);
        check("R2 lag", {31'd0, core_halt}, 0);
        @(negedge clk);
        check("R2 core_halt", {31'd0, core_halt}, 1);
        bus_read(2'd0, w); check("R2 ctrl", w, 32'h0001_0003);

        // R9/R11 write sweep over every selector code
        for (int i = 0; i < 32; i++) begin
            rc = req_count;
            bus_write(2'd2, pat(i));
            bus_write(2'd1, 32'h0001_0000 | i);
            bus_read(2'd0, w); check("R7 ready cleared", {31'd0, w[17]}, 0);
            wait_ready(got);
            if (i < NREG) begin
                check("R9 ready", {31'd0, got}, 1);
                check("R9 creg", cregs[i], pat(i));
            end else begin
                check("R11 ready", {31'd0, got}, 0);
                check("R11 req count", rc, req_count);
            end
        end
        for (int i = 0; i < NREG; i++) check("R11 bank intact", cregs[i], pat(i));

        // R8/R11 read sweep
        bus_write(2'd2, 32'hDEADBEEF);
        for (int i = 0; i < 32; i++) begin
            bus_write(2'd1, i);
            bus_read(2'd1, w); check("R7 sel readback", w, i);
            wait_ready(got);
            bus_read(2'd2, w);
            if (i < NREG) begin
                check("R8 ready", {31'd0, got}, 1);
                check("R8 data", w, pat(i));
            end else begin
                check("R11 read ready", {31'd0, got}, 0);
                check("R11 data kept", w, pat(NREG - 1));
            end
        end

        // R12 ready holds until the next selector write
        bus_write(2'd1, 0);
        wait_ready(got);
        repeat (3) @(negedge clk);
        bus_read(2'd0, w); check("R12 ready held", {31'd0, w[17]}, 1);

        // R4 release with lag of one clock
        bus_write(2'd0, 32'h1);
        check("R4 lag", {31'd0, core_halt}, 1);
        @(negedge clk);
        check("R4 core_halt", {31'd0, core_halt}, 0);

        // R5 breakpoint and watchpoint halt while enabled
        pulse(1'b1);
        check("R5 bkpt lag", {31'd0, core_halt}, 0);
        @(negedge clk);
        check("R5 bkpt halt", {31'd0, core_halt}, 1);
        repeat (3) @(negedge clk);
        bus_read(2'd0, w); check("R5 sticky", w[1:0], 2'b11);
        bus_write(2'd0, 32'h1);
        @(negedge clk);
        check("R4 released", {31'd0, core_halt}, 0);
        pulse(1'b0);
        @(negedge clk);
        check("R5 wpt halt", {31'd0, core_halt}, 1);

        // R4 clearing enable also releases
        bus_write(2'd0, 32'h0);
        @(negedge clk);
        check("R4 disable", {31'd0, core_halt}, 0);
        bus_read(2'd0, w); check("R4 ctrl", w[1:0], 2'b00);
        summary();
    end
endmodule